// File: doc/BRIEF.md
# CPU Bus Slave with Interrupt Vectoring

This block is the processor-facing side of a peripheral. An external CPU reaches a small set of registers through an asynchronous strobed bus, and the block answers each transfer with an active-low acknowledge. The bus has an active-low select, a read/write level, six address lines and separate 8-bit data-in and data-out paths. Three-state pads are modelled as a value plus an output-enable.

Eight interrupt sources latch into sticky pending bits. Pending bits that are enabled in a mask pull an active-low request low. When the CPU runs an interrupt-acknowledge cycle, the block returns a vector from a register. If the status-modify control bit is set, the low three vector bits are replaced by the number of the most urgent enabled pending source. If nothing enabled is pending, the block stays silent and drives its daisy-chain output low instead, so the acknowledge passes to lower-priority devices.

The select and acknowledge strobes each pass through a two-flop synchronizer. Address, read/write and write data are sampled directly, so they must be stable from the falling strobe until the acknowledge appears. A reset input clears the block asynchronously.

Top module: `cbi_top`

## Requirements
- R1: While reset is active and right after it, xfer_ack_oe, data_oe and irq_n read 0/0/1, chain_out_n is 1, and the registers read zero.
- R2: A write cycle (cs_n low, rw low) updates the register chosen by addr on the third rising clock after cs_n falls. In that same cycle xfer_ack_n goes low and xfer_ack_oe goes high. The registers are: 0 enable mask, 1 pending status, 2 vector, 3 control (bit 0 = status-modify).
- R3: A read cycle (rw high) drives data_out with the addressed register and sets data_oe on the third rising clock after cs_n falls, together with the acknowledge. Addresses 4 and up read zero and ignore writes. Pending status reads in bit i for source i.
- R4: On the third rising clock after the ending strobe rises, xfer_ack_n is driven high and data_oe drops. One clock later xfer_ack_oe drops to high impedance.
- R5: A source input high at a rising clock sets its pending bit. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: irq_n is low exactly when some pending bit has its mask bit set. The change shows in the clock after the pending or mask change.
- R7: An interrupt-acknowledge cycle with an enabled pending source acknowledges on the third clock after iack_n falls, drives the vector unmodified when status-modify is 0, and keeps chain_out_n high.
- R8: With status-modify set, vector bits 2:0 are replaced by the lowest-numbered enabled pending source. Source 0 is the most urgent.
- R9: An interrupt-acknowledge cycle with nothing enabled pending never drives the acknowledge or the data. chain_out_n goes low on the third clock after iack_n falls and returns high on the third clock after iack_n rises.
- R10: Asserting rst_n low clears the outputs and registers immediately, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low register select strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Register address |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read or vector data to the bus |
| data_oe | output | 1 | Data bus drive enable |
| iack_n | input | 1 | Active-low interrupt-acknowledge strobe |
| xfer_ack_n | output | 1 | Transfer acknowledge value (active low) |
| xfer_ack_oe | output | 1 | Transfer acknowledge drive enable |
| irq_src | input | 8 | Interrupt source conditions, one per bit |
| irq_n | output | 1 | Active-low interrupt request |
| chain_out_n | output | 1 | Active-low daisy-chain acknowledge to lower-priority devices |

## Verification
Every bus or acknowledge result appears on the third rising clock after the strobe edge: two synchronizer flops, then the registered handshake stage. Acknowledge release takes three clocks, and the high-impedance return takes a fourth. The interrupt request follows one clock after a source pulse or a status write. The driver records each expectation against an absolute cycle number taken at the moment it moves a strobe. The monitor compares at the falling edge of exactly that cycle. It also checks the cycle just before each acknowledge, so an early response is flagged as well as a late one.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_NEG  = 2'd2,
    ST_PASS = 2'd3
  } cbi_state_e;

  localparam int REG_MASK = 0;
  localparam int REG_STAT = 1;
  localparam int REG_VEC  = 2;
  localparam int REG_CTRL = 3;
  localparam int NUM_REGS = 4;
endpackage

// File: rtl/cbi_sync.sv
module cbi_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cbi_prio.sv
module cbi_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

  // R8: the chosen index is requesting and nothing below it is
  always_comb begin
    if (any) begin
      assert_prio_lowest_R8: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/cbi_regs.sv
module cbi_regs
  import cbi_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [N_SRC-1:0] src,
  output logic [DW-1:0]    rdata,
  output logic [N_SRC-1:0] active,
  output logic [DW-1:0]    vector,
  output logic             modify
);
  logic [N_SRC-1:0] mask_q, pend_q, clr;
  logic [DW-1:0]    vec_q;
  logic             mod_q;

  assign clr = (wr_en && addr == AW'(REG_STAT)) ? wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      vec_q  <= '0;
      mod_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | src;
      if (wr_en) begin
        case (addr)
          AW'(REG_MASK): mask_q <= wdata[N_SRC-1:0];
          AW'(REG_VEC):  vec_q  <= wdata;
          AW'(REG_CTRL): mod_q  <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(REG_MASK): rdata = DW'(mask_q);
      AW'(REG_STAT): rdata = DW'(pend_q);
      AW'(REG_VEC):  rdata = vec_q;
      AW'(REG_CTRL): rdata = DW'(mod_q);
      default:       rdata = '0;
    endcase
  end

  assign active = pend_q & mask_q;
  assign vector = vec_q;
  assign modify = mod_q;

  // R2: the mask only moves on a bus write
  assert_mask_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

  // R5: a pending bit only rises after its source was high
  for (genvar i = 0; i < N_SRC; i++) begin : g_pend_chk
    assert_pend_from_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(src[i]));
  end
endmodule

// File: rtl/cbi_top.sv
module cbi_top
  import cbi_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    data_out,
  output logic             data_oe,
  input  logic             iack_n,
  output logic             xfer_ack_n,
  output logic             xfer_ack_oe,
  input  logic [N_SRC-1:0] irq_src,
  output logic             irq_n,
  output logic             chain_out_n
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             cs_s, iack_s, wr_en, modify, any;
  logic [DW-1:0]    rdata, vector, vec_out;
  logic [N_SRC-1:0] active;
  logic [IW-1:0]    idx;

  cbi_state_e    state;
  logic          ack_n_q, ack_oe_q, doe_q, is_iack_q, chain_n_q;
  logic [DW-1:0] dout_q;

  cbi_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, iack_n}), .q({cs_s, iack_s})
  );

  assign wr_en = (state == ST_IDLE) && !cs_s && !rw;

  cbi_regs #(.DW(DW), .AW(AW), .N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(data_in),
    .src(irq_src), .rdata(rdata), .active(active), .vector(vector), .modify(modify)
  );

  cbi_prio #(.N(N_SRC), .IW(IW)) u_prio (.req(active), .idx(idx), .any(any));

  assign vec_out = modify ? {vector[DW-1:IW], idx} : vector;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_n_q   <= 1'b1;
      ack_oe_q  <= 1'b0;
      doe_q     <= 1'b0;
      dout_q    <= '0;
      is_iack_q <= 1'b0;
      chain_n_q <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!cs_s) begin
            state     <= ST_ACK;
            ack_n_q   <= 1'b0;
            ack_oe_q  <= 1'b1;
            is_iack_q <= 1'b0;
            doe_q     <= rw;
            dout_q    <= rdata;
          end else if (!iack_s) begin
            if (any) begin
              state     <= ST_ACK;
              ack_n_q   <= 1'b0;
              ack_oe_q  <= 1'b1;
              is_iack_q <= 1'b1;
              doe_q     <= 1'b1;
              dout_q    <= vec_out;
            end else begin
              state     <= ST_PASS;
              chain_n_q <= 1'b0;
            end
          end
        end
        ST_ACK: begin
          if (is_iack_q ? iack_s : cs_s) begin
            state   <= ST_NEG;
            ack_n_q <= 1'b1;
            doe_q   <= 1'b0;
          end
        end
        ST_NEG: begin
          state    <= ST_IDLE;
          ack_oe_q <= 1'b0;
        end
        ST_PASS: begin
          if (iack_s) begin
            state     <= ST_IDLE;
            chain_n_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign data_out    = dout_q;
  assign data_oe     = doe_q;
  assign xfer_ack_n  = ack_n_q;
  assign xfer_ack_oe = ack_oe_q;
  assign chain_out_n = chain_n_q;
  assign irq_n       = !any;

  // R3: data is only driven while the acknowledge is asserted
  assert_doe_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (xfer_ack_oe && !xfer_ack_n));

  // R4: a driven-high acknowledge floats on the next clock
  assert_neg_then_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack_oe && xfer_ack_n) |=> !xfer_ack_oe);

  // R9: passing the chain never coexists with a driven acknowledge
  assert_pass_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_out_n |-> (!xfer_ack_oe && !data_oe));

  // R7: a vector acknowledge requires an enabled pending source
  assert_iack_needs_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xfer_ack_n) && is_iack_q) |-> $past(any));
endmodule

// File: tb/sim_cbi_top.sv
`timescale 1ns/1ps
module sim_cbi_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rw = 1'b1, iack_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] data_in = '0, irq_src = '0;
  logic [7:0] data_out;
  logic       data_oe, xfer_ack_n, xfer_ack_oe, irq_n, chain_out_n;

  always #4 clk = ~clk;

  cbi_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .iack_n(iack_n), .xfer_ack_n(xfer_ack_n), .xfer_ack_oe(xfer_ack_oe),
    .irq_src(irq_src), .irq_n(irq_n), .chain_out_n(chain_out_n)
  );

  // observed bits: {chain(12), irq(11), doe(10), dout(9:2), ack_n(1), ack_oe(0)}
  typedef struct {
    int          cyc;
    string       req;
    logic [12:0] val;
    logic [12:0] care;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void push(int c, string r, logic [12:0] v, logic [12:0] m);
    exp_t e;
    e.cyc = c; e.req = r; e.val = v; e.care = m;
    sb.push_back(e);
  endfunction

  // monitor: pops every expectation due in this cycle
  always @(negedge clk) begin
    exp_t e;
    logic [12:0] obs;
    obs = {chain_out_n, irq_n, data_oe, data_out, xfer_ack_n, xfer_ack_oe};
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      e = sb.pop_front();
      n_cmp++;
      if (((obs ^ e.val) & e.care) != '0) begin
        n_bad++;
        $display("FAIL %s cyc=%0d actual=%h expected=%h care=%h",
                 e.req, cyc, obs, e.val, e.care);
      end
    end
  end

  localparam logic [12:0] M_ACK  = 13'h0003;
  localparam logic [12:0] M_DOE  = 13'h0400;
  localparam logic [12:0] M_DATA = 13'h07FC;
  localparam logic [12:0] M_IRQ  = 13'h0800;
  localparam logic [12:0] M_CHN  = 13'h1000;

  task automatic bus_cycle(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                           input logic [7:0] exp_rd, input string r);
    int c;
    @(negedge clk);
    c = cyc; cs_n = 1'b0; rw = rd; addr = a; data_in = wd;
    push(c + 2, r, 13'h0002, M_ACK);
    if (rd) push(c + 3, r, {3'b001, exp_rd, 2'b01}, M_DATA | M_ACK);
    else    push(c + 3, r, 13'h0001, M_DOE | M_ACK);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    push(c + 6, r, 13'h0001, M_ACK);
    push(c + 7, "R4", 13'h0003, M_DOE | M_ACK);
    push(c + 8, "R4", 13'h0002, M_DOE | 13'h0001);
    repeat (5) @(negedge clk);
  endtask

  task automatic iack_cycle(input bit hit, input logic [7:0] vec, input string r);
    int c;
    @(negedge clk);
    c = cyc; iack_n = 1'b0;
    push(c + 2, r, 13'h1002, M_CHN | M_ACK);
    if (hit) push(c + 3, r, {3'b101, vec, 2'b01}, M_CHN | M_DATA | M_ACK);
    else     push(c + 3, "R9", 13'h0000, M_CHN | M_DOE | 13'h0001);
    repeat (4) @(negedge clk);
    iack_n = 1'b1;
    if (hit) begin
      push(c + 7, "R4", 13'h1003, M_CHN | M_DOE | M_ACK);
      push(c + 8, "R4", 13'h1000, M_CHN | 13'h0001);
    end else begin
      push(c + 6, "R9", 13'h0000, M_CHN | 13'h0001);
      push(c + 7, "R9", 13'h1000, M_CHN | 13'h0001);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_src(input int i);
    @(negedge clk);
    irq_src = 8'(1 << i);
    @(negedge clk);
    irq_src = '0;
  endtask

  task automatic print_summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    push(cyc + 1, "R1", 13'h1802, M_CHN | M_IRQ | M_DOE | 13'h0001);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    push(cyc + 1, "R1", 13'h1802, M_CHN | M_IRQ | M_DOE | 13'h0001);
    repeat (2) @(negedge clk);
    bus_cycle(1, 6'd0, 8'h00, 8'h00, "R1");   // mask reads zero
    bus_cycle(1, 6'd2, 8'h00, 8'h00, "R1");   // vector reads zero
    bus_cycle(0, 6'd0, 8'hA5, 8'h00, "R2");   // write mask
    bus_cycle(1, 6'd0, 8'h00, 8'hA5, "R3");
    bus_cycle(0, 6'd2, 8'h40, 8'h00, "R2");   // write vector
    bus_cycle(1, 6'd2, 8'h00, 8'h40, "R3");
    bus_cycle(0, 6'd6, 8'hFF, 8'h00, "R3");   // unmapped write ignored
    bus_cycle(1, 6'd6, 8'h00, 8'h00, "R3");
    bus_cycle(1, 6'd0, 8'h00, 8'hA5, "R3");
    iack_cycle(0, 8'h00, "R9");               // nothing pending
    pulse_src(1);                             // masked source
    push(cyc + 1, "R6", 13'h0800, M_IRQ);
    bus_cycle(1, 6'd1, 8'h00, 8'h02, "R5");
    pulse_src(5);                             // enabled source
    push(cyc + 1, "R6", 13'h0000, M_IRQ);
    repeat (2) @(negedge clk);
    iack_cycle(1, 8'h40, "R7");
    bus_cycle(0, 6'd3, 8'h01, 8'h00, "R2");   // status-modify on
    bus_cycle(1, 6'd3, 8'h00, 8'h01, "R3");
    iack_cycle(1, 8'h45, "R8");
    pulse_src(2);
    bus_cycle(0, 6'd2, 8'h47, 8'h00, "R2");
    iack_cycle(1, 8'h42, "R8");               // sources 2 and 5: 2 wins, bits replaced
    bus_cycle(0, 6'd1, 8'h00, 8'h00, "R5");   // zeros clear nothing
    bus_cycle(1, 6'd1, 8'h00, 8'h26, "R5");
    bus_cycle(0, 6'd1, 8'h04, 8'h00, "R5");
    bus_cycle(1, 6'd1, 8'h00, 8'h22, "R5");
    push(cyc + 1, "R6", 13'h0000, M_IRQ);
    bus_cycle(0, 6'd1, 8'h20, 8'h00, "R5");
    push(cyc + 1, "R6", 13'h0800, M_IRQ);     // only masked source left
    bus_cycle(1, 6'd1, 8'h00, 8'h02, "R5");
    iack_cycle(0, 8'h00, "R9");
    // R10: asynchronous reset in the middle of an acknowledged read
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; addr = 6'd0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    n_cmp++;
    if (xfer_ack_oe !== 1'b0 || data_oe !== 1'b0 || irq_n !== 1'b1 || chain_out_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 actual ack_oe=%b doe=%b irq_n=%b chain=%b expected 0 0 1 1",
               xfer_ack_oe, data_oe, irq_n, chain_out_n);
    end
    cs_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_cycle(1, 6'd0, 8'h00, 8'h00, "R10");
    bus_cycle(1, 6'd1, 8'h00, 8'h00, "R10");
    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad += sb.size();
      $display("FAIL all %0d expectations left unchecked, expected 0", sb.size());
    end
    done = 1'b1;
    print_summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all requirements: actual hung, expected completion");
      print_summary();
      $finish;
    end
  end
endmodule